// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block holds four small registers, named A, B, C and G, that trade values over one internal bus. A source code picks which register drives the bus through a four-way multiplexer. A destination code goes through a two-to-four decoder that raises the load line of a single register. That register takes the bus value on the next rising clock edge. The two codes together form a four-bit control word `{dst_sel, src_sel}` with 16 values. Each value is a legal one-cycle move, and the four values with equal halves copy a register onto itself.

A separate initialization port writes a chosen register directly from outside, so a test sequence or a controller can set starting values. A transfer happens only while the transfer-enable input is high. All four register values and the live bus value are outputs, so every move can be compared with a reference model.

Top module: `rt_xfer_datapath`

## Requirements
- R1: While `rst_n` is low, all four registers read zero. The reset acts without waiting for a clock edge.
- R2: `bus_val` combinationally shows the register that `src_sel` chooses. Code 0 selects A, 1 selects B, 2 selects C and 3 selects G.
- R3: With `xfer_en` high and `init_we` low, the register chosen by `dst_sel` captures `bus_val` on the rising edge. The code map is the same as for R2 (0 A, 1 B, 2 C, 3 G).
- R4: At most one transfer load line is active at a time, and every register other than the destination keeps its value.
- R5: When `src_sel` equals `dst_sel`, the transfer leaves all registers unchanged.
- R6: With `xfer_en` low and `init_we` low, no register changes on a clock edge.
- R7: With `init_we` high, the register chosen by `init_idx` (0 A, 1 B, 2 C, 3 G) captures `init_data` on the rising edge.
- R8: With `init_we` high, any transfer requested in the same cycle is dropped, even when its destination differs from `init_idx`.
- R9: Each of the 16 control words `{dst_sel, src_sel}` completes its move in a single clock cycle. Register values are `WIDTH` bits wide, and bit `WIDTH-1` is the most significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_en | input | 1 | Enables the bus transfer this cycle |
| src_sel | input | 2 | Register that drives the bus |
| dst_sel | input | 2 | Register that loads from the bus |
| init_we | input | 1 | Strobe for an external register write |
| init_idx | input | 2 | Register targeted by the external write |
| init_data | input | WIDTH | Value for the external write |
| reg_a | output | WIDTH | Contents of register A |
| reg_b | output | WIDTH | Contents of register B |
| reg_c | output | WIDTH | Contents of register C |
| reg_g | output | WIDTH | Contents of register G |
| bus_val | output | WIDTH | Current value on the transfer bus |

## Verification
The assertions assume that the select inputs and the strobes are known, two-state values at every clock edge once reset is released. They also assume the reset is asserted asynchronously at least once before the clock starts. The stimulus drives every control input on the falling edge and never leaves one undriven. The stimulus lowers `rst_n` before the first rising edge and keeps it low for several cycles. A mid-run reset is also applied between falling edges, so every edge sees settled inputs.

// File: rtl/rt_xfer_pkg.sv
package rt_xfer_pkg;
  localparam int NUM_REGS = 4;
  localparam int SEL_W    = $clog2(NUM_REGS);

  typedef logic [SEL_W-1:0] reg_idx_t;

  // Fixed code map of the four registers.
  typedef enum logic [SEL_W-1:0] {
    RID_A = 2'd0,
    RID_B = 2'd1,
    RID_C = 2'd2,
    RID_G = 2'd3
  } reg_id_e;

  // Binary index to one-hot line vector, gated by an enable.
  function automatic logic [NUM_REGS-1:0] idx_to_lines(input reg_idx_t idx, input logic en);
    logic [NUM_REGS-1:0] lines;
    lines = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      lines[i] = en && (idx == reg_idx_t'(i));
    end
    return lines;
  endfunction
endpackage

// File: rtl/rt_src_mux.sv
module rt_src_mux #(
  parameter int W  = 4,
  parameter int N  = 4,
  parameter int SW = 2
) (
  input  logic [N*W-1:0] din,
  input  logic [SW-1:0]  sel,
  output logic [W-1:0]   dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      if (sel == SW'(i)) dout = din[i*W +: W];
    end
  end
endmodule

// File: rtl/rt_dst_decoder.sv
module rt_dst_decoder
  import rt_xfer_pkg::*;
(
  input  logic                en,
  input  reg_idx_t            sel,
  output logic [NUM_REGS-1:0] lines
);
  assign lines = idx_to_lines(sel, en);
endmodule

// File: rtl/rt_reg_slice.sv
module rt_reg_slice #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_ld,
  input  logic [W-1:0] init_d,
  input  logic         xfer_ld,
  input  logic [W-1:0] bus_d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (init_ld) begin
      q <= init_d;
    end else if (xfer_ld) begin
      q <= bus_d;
    end
  end
endmodule

// File: rtl/rt_xfer_datapath.sv
module rt_xfer_datapath
  import rt_xfer_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_en,
  input  logic [1:0]       src_sel,
  input  logic [1:0]       dst_sel,
  input  logic             init_we,
  input  logic [1:0]       init_idx,
  input  logic [WIDTH-1:0] init_data,
  output logic [WIDTH-1:0] reg_a,
  output logic [WIDTH-1:0] reg_b,
  output logic [WIDTH-1:0] reg_c,
  output logic [WIDTH-1:0] reg_g,
  output logic [WIDTH-1:0] bus_val
);
  localparam int FLAT_W = NUM_REGS * WIDTH;

  logic [FLAT_W-1:0]   regs_flat;
  logic [NUM_REGS-1:0] ld_vec;
  logic [NUM_REGS-1:0] init_vec;
  logic                xfer_go;

  // An external write wins the cycle: the bus move is dropped.
  assign xfer_go = xfer_en && !init_we;

  rt_src_mux #(.W(WIDTH), .N(NUM_REGS), .SW(SEL_W)) u_mux (
    .din  (regs_flat),
    .sel  (src_sel),
    .dout (bus_val)
  );

  rt_dst_decoder u_xfer_dec (
    .en    (xfer_go),
    .sel   (dst_sel),
    .lines (ld_vec)
  );

  rt_dst_decoder u_init_dec (
    .en    (init_we),
    .sel   (init_idx),
    .lines (init_vec)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slice
    rt_reg_slice #(.W(WIDTH)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .init_ld (init_vec[i]),
      .init_d  (init_data),
      .xfer_ld (ld_vec[i]),
      .bus_d   (bus_val),
      .q       (regs_flat[i*WIDTH +: WIDTH])
    );
  end

  assign reg_a = regs_flat[RID_A*WIDTH +: WIDTH];
  assign reg_b = regs_flat[RID_B*WIDTH +: WIDTH];
  assign reg_c = regs_flat[RID_C*WIDTH +: WIDTH];
  assign reg_g = regs_flat[RID_G*WIDTH +: WIDTH];
endmodule

// File: rtl/rt_xfer_checker.sv
module rt_xfer_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         xfer_en,
  input logic [1:0]   src_sel,
  input logic [1:0]   dst_sel,
  input logic         init_we,
  input logic [1:0]   init_idx,
  input logic [W-1:0] init_data,
  input logic [W-1:0] bus_val,
  input logic [4*W-1:0] regs_flat,
  input logic [3:0]   ld_vec
);
  function automatic logic [W-1:0] pick(input logic [4*W-1:0] v, input logic [1:0] i);
    return v[i*W +: W];
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (regs_flat == '0) else $error("reset clear"); // R1
    end
  end

  AST_BUS_FOLLOWS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    bus_val == pick(regs_flat, src_sel)) else $error("bus source"); // R2

  AST_XFER_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && !init_we) |=> pick(regs_flat, $past(dst_sel)) == $past(bus_val))
    else $error("transfer dest"); // R3

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_vec)) else $error("load lines"); // R4

  for (genvar i = 0; i < 4; i++) begin : g_hold
    AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_we && !(xfer_en && dst_sel == 2'(i))) |=> $stable(regs_flat[i*W +: W]))
      else $error("non-target changed"); // R4
  end

  AST_SELF_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && !init_we && src_sel == dst_sel) |=> $stable(regs_flat))
    else $error("self copy"); // R5

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_en && !init_we) |=> $stable(regs_flat)) else $error("idle"); // R6

  AST_INIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    init_we |=> pick(regs_flat, $past(init_idx)) == $past(init_data))
    else $error("init write"); // R7

  AST_INIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    init_we |-> ld_vec == 4'b0000) else $error("init priority"); // R8
endmodule

bind rt_xfer_datapath rt_xfer_checker #(.W(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xfer_en   (xfer_en),
  .src_sel   (src_sel),
  .dst_sel   (dst_sel),
  .init_we   (init_we),
  .init_idx  (init_idx),
  .init_data (init_data),
  .bus_val   (bus_val),
  .regs_flat (regs_flat),
  .ld_vec    (ld_vec)
);

// File: tb/sim_rt_xfer_datapath.sv
`timescale 1ns/1ps
module sim_rt_xfer_datapath;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       xfer_en = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic [1:0] dst_sel = 2'd0;
  logic       init_we = 1'b0;
  logic [1:0] init_idx = 2'd0;
  logic [3:0] init_data = 4'd0;
  logic [3:0] reg_a, reg_b, reg_c, reg_g, bus_val;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int mdl[4];
  logic [7:0] lfsr = 8'hA5;

  always #5 clk = ~clk;

  rt_xfer_datapath #(.WIDTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .src_sel(src_sel),
    .dst_sel(dst_sel), .init_we(init_we), .init_idx(init_idx),
    .init_data(init_data), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
    .reg_g(reg_g), .bus_val(bus_val)
  );

  function automatic int port_val(input int i);
    case (i)
      0: return int'(reg_a);
      1: return int'(reg_b);
      2: return int'(reg_c);
      default: return int'(reg_g);
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int i = 0; i < 4; i++) chk(tag, port_val(i), mdl[i]);
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic do_cycle(input logic xe, input int s, input int d, input logic iw,
                          input int ii, input int id, input string tag);
    int nxt[4];
    xfer_en = xe; src_sel = 2'(s); dst_sel = 2'(d);
    init_we = iw; init_idx = 2'(ii); init_data = 4'(id);
    #1;
    chk("R2 bus source", int'(bus_val), mdl[s]);
    nxt = mdl;
    if (iw) nxt[ii] = id;
    else if (xe) nxt[d] = mdl[s];
    @(posedge clk);
    mdl = nxt;
    @(negedge clk);
    chk_all(tag);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    for (int i = 0; i < 4; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    chk_all("R1 reset zero");
    rst_n = 1'b1;
    @(negedge clk);

    // R7: external writes, value 7 is 0111 (R9 bit order)
    do_cycle(0, 0, 0, 1, 0, 7, "R7 init A");
    do_cycle(0, 0, 0, 1, 1, 10, "R7 init B");
    do_cycle(0, 0, 0, 1, 2, 12, "R7 init C");
    do_cycle(0, 0, 0, 1, 3, 9, "R7 init G");
    chk("R9 msb of A", int'(reg_a[3]), 0);

    // R3/R9: sweep all 16 control words {dst,src}
    for (int w = 0; w < 16; w++) begin
      do_cycle(1, w % 4, w / 4, 0, 0, 0, (w % 4 == w / 4) ? "R5 self copy" : "R3 R9 transfer");
      do_cycle(0, 0, 0, 1, w % 4, (w * 5 + 3) % 16, "R7 refresh");
    end

    // R6: enable low, differing codes
    do_cycle(0, 1, 2, 0, 0, 0, "R6 idle");
    do_cycle(0, 3, 0, 0, 0, 0, "R6 idle");

    // R8: init and transfer in same cycle, different targets
    do_cycle(1, 0, 3, 1, 1, 6, "R8 init wins");
    do_cycle(1, 2, 2, 1, 2, 15, "R8 init wins same");

    // R4: pseudo-random mix
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      do_cycle(lfsr[0] | lfsr[7], int'(lfsr[2:1]), int'(lfsr[4:3]),
               lfsr[6] & lfsr[5], int'(lfsr[5:4]), int'(lfsr[7:4]), "R4 random");
    end

    // R1: asynchronous reset mid-run
    #2 rst_n = 1'b0;
    for (int i = 0; i < 4; i++) mdl[i] = 0;
    #1 chk_all("R1 async clear");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_cycle(0, 0, 1, 1, 3, 5, "R7 after reset");
    do_cycle(1, 3, 1, 0, 0, 0, "R3 after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule